// File: doc/BRIEF.md
# Exception Entry Sequencer

This block turns a pending exception code into the register updates a processor core needs when it enters a handler. When the strobe is high, the block takes the code, the current program counter, the current status word and the high-vector control bit. It works out the handler mode and the vector address. It also produces the new status word, the value for the saved-status register, the return (link) value, and a request to the register-bank switcher. All results are registered. They appear together one cycle after the strobe, marked by a single-cycle done pulse.

A code outside the four defined values is rejected. It raises a one-cycle error pulse and leaves every result register as it was. The block does not pick between simultaneous exceptions and does not flush the pipeline. The surrounding core does both before it presents a code.

The control is a three-state machine:
- ST_IDLE: no result is pending.
- ST_ENTER: a valid entry has just been registered; done is high.
- ST_REJECT: an unknown code was seen; err is high.

From every state the machine moves as follows:
- Strobe with a known code: go to ST_ENTER (transition "accept").
- Strobe with an unknown code: go to ST_REJECT (transition "reject").
- No strobe: go to ST_IDLE (transition "settle").

Top module: `trap_entry_seq`

## Requirements
- R1: Code 1 (supervisor call) selects handler mode 0x13 and vector offset 0x08.
- R2: Code 2 (fetch abort) selects mode 0x17 with offset 0x0C. Code 3 (data abort) selects mode 0x17 with offset 0x10.
- R3: Code 4 (interrupt) selects mode 0x12 and vector offset 0x18.
- R4: When hivec_en is 1 at the strobe, the vector is the offset plus 0xFFFF0000. Otherwise it is the offset alone.
- R5: new_status equals cur_status with two changes: bits [4:0] (mode field) hold the handler mode, and bit 7 (interrupt disable) is 1.
- R6: saved_status equals cur_status exactly as it was at the strobe.
- R7: link_val equals cur_pc at the strobe, unchanged, and new_pc equals the vector.
- R8: bank_old_mode carries cur_status[4:0] and bank_new_mode carries the handler mode. bank_req pulses together with done only when these two modes differ.
- R9: For codes 0, 5, 6 and 7, err is high for one cycle, done and bank_req stay low, and new_pc, new_status, saved_status and link_val keep their previous values.
- R10: Results are registered. done is high exactly in the cycle after each strobe with a known code, and low in a cycle after no strobe.
- R11: After reset, done, err and bank_req are 0, and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception strobe |
| exc_code | input | 3 | Exception code |
| cur_pc | input | 32 | Current program counter |
| cur_status | input | 32 | Current status word |
| hivec_en | input | 1 | Relocate vectors to the high base |
| done | output | 1 | Entry results valid (one cycle) |
| err | output | 1 | Unknown code rejected (one cycle) |
| new_pc | output | 32 | Handler vector address |
| new_status | output | 32 | Status word for the handler |
| saved_status | output | 32 | Value for the saved-status register |
| link_val | output | 32 | Return address for the link register |
| bank_req | output | 1 | Request a register-bank switch |
| bank_old_mode | output | 5 | Mode being left |
| bank_new_mode | output | 5 | Mode being entered |

## Verification
Any internal fault shows at the ports in the cycle right after the strobe, because every result register loads on that edge. A wrong state in the machine shows as done or err at the wrong time: a pulse that lasts too long, or a pulse where none should be. A decode slip shows as a wrong mode field or vector in that same cycle. A result register that loads when it should hold shows on the err cycle: new_pc or new_status change when they should keep the previous values.

// File: rtl/trap_entry_pkg.sv
`timescale 1ns/1ps
package trap_entry_pkg;

    localparam int MODE_W  = 5;
    localparam int OFFS_W  = 8;

    localparam int EXC_SUPV_CALL   = 1;
    localparam int EXC_FETCH_ABORT = 2;
    localparam int EXC_DATA_ABORT  = 3;
    localparam int EXC_IRQ         = 4;

    localparam logic [MODE_W-1:0] MODE_SUPV  = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABORT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_IRQ   = 5'h12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ENTER,
        ST_REJECT
    } seq_state_e;

    typedef struct packed {
        logic              known;
        logic [MODE_W-1:0] mode;
        logic [OFFS_W-1:0] offset;
    } entry_info_t;

endpackage

// File: rtl/trap_vec_decode.sv
`timescale 1ns/1ps
module trap_vec_decode
    import trap_entry_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code,
    output entry_info_t       info
);

    always_comb begin
        info = '0;
        case (code)
            CODE_W'(EXC_SUPV_CALL): begin
                info.known  = 1'b1;
                info.mode   = MODE_SUPV;
                info.offset = 8'h08;
            end
            CODE_W'(EXC_FETCH_ABORT): begin
                info.known  = 1'b1;
                info.mode   = MODE_ABORT;
                info.offset = 8'h0c;
            end
            CODE_W'(EXC_DATA_ABORT): begin
                info.known  = 1'b1;
                info.mode   = MODE_ABORT;
                info.offset = 8'h10;
            end
            CODE_W'(EXC_IRQ): begin
                info.known  = 1'b1;
                info.mode   = MODE_IRQ;
                info.offset = 8'h18;
            end
            default: info = '0;
        endcase
    end

endmodule

// File: rtl/trap_vec_reloc.sv
`timescale 1ns/1ps
module trap_vec_reloc
    import trap_entry_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] HIVEC_BASE = 32'hFFFF_0000
) (
    input  logic [OFFS_W-1:0] offset,
    input  logic              hivec_en,
    output logic [XLEN-1:0]   vector
);

    logic [XLEN-1:0] base_sel;

    always_comb begin
        base_sel = hivec_en ? HIVEC_BASE : '0;
        vector   = XLEN'(offset) + base_sel;
    end

endmodule

// File: rtl/trap_status_build.sv
`timescale 1ns/1ps
module trap_status_build
    import trap_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int IDIS_BIT = 7
) (
    input  logic [XLEN-1:0]   cur_status,
    input  logic [MODE_W-1:0] mode,
    output logic [XLEN-1:0]   next_status
);

    always_comb begin
        next_status               = cur_status;
        next_status[MODE_W-1:0]   = mode;
        next_status[IDIS_BIT]     = 1'b1;
    end

endmodule

// File: rtl/trap_entry_seq.sv
`timescale 1ns/1ps
module trap_entry_seq
    import trap_entry_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              CODE_W     = 3,
    parameter int              IDIS_BIT   = 7,
    parameter logic [XLEN-1:0] HIVEC_BASE = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_status,
    input  logic              hivec_en,
    output logic              done,
    output logic              err,
    output logic [XLEN-1:0]   new_pc,
    output logic [XLEN-1:0]   new_status,
    output logic [XLEN-1:0]   saved_status,
    output logic [XLEN-1:0]   link_val,
    output logic              bank_req,
    output logic [MODE_W-1:0] bank_old_mode,
    output logic [MODE_W-1:0] bank_new_mode
);

    seq_state_e      state_q, state_d;
    entry_info_t     info;
    logic [XLEN-1:0] vector;
    logic [XLEN-1:0] status_next;
    logic            accept;
    logic            reject;
    logic            mode_change;

    trap_vec_decode #(.CODE_W(CODE_W)) u_decode (
        .code (exc_code),
        .info (info)
    );

    trap_vec_reloc #(.XLEN(XLEN), .HIVEC_BASE(HIVEC_BASE)) u_reloc (
        .offset   (info.offset),
        .hivec_en (hivec_en),
        .vector   (vector)
    );

    trap_status_build #(.XLEN(XLEN), .IDIS_BIT(IDIS_BIT)) u_status (
        .cur_status  (cur_status),
        .mode        (info.mode),
        .next_status (status_next)
    );

    assign accept      = exc_valid &  info.known;
    assign reject      = exc_valid & ~info.known;
    assign mode_change = (cur_status[MODE_W-1:0] != info.mode);

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (accept)      state_d = ST_ENTER;
                else if (reject) state_d = ST_REJECT;
                else             state_d = ST_IDLE;
            end
            ST_ENTER: begin
                if (accept)      state_d = ST_ENTER;
                else if (reject) state_d = ST_REJECT;
                else             state_d = ST_IDLE;
            end
            ST_REJECT: begin
                if (accept)      state_d = ST_ENTER;
                else if (reject) state_d = ST_REJECT;
                else             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result registers: load only on an accepted entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_pc        <= '0;
            new_status    <= '0;
            saved_status  <= '0;
            link_val      <= '0;
            bank_req      <= 1'b0;
            bank_old_mode <= '0;
            bank_new_mode <= '0;
        end else begin
            bank_req <= 1'b0;
            if (accept) begin
                new_pc        <= vector;
                new_status    <= status_next;
                saved_status  <= cur_status;
                link_val      <= cur_pc;
                bank_req      <= mode_change;
                bank_old_mode <= cur_status[MODE_W-1:0];
                bank_new_mode <= info.mode;
            end
        end
    end

    assign done = (state_q == ST_ENTER);
    assign err  = (state_q == ST_REJECT);

endmodule

// File: rtl/trap_entry_seq_chk.sv
`timescale 1ns/1ps
module trap_entry_seq_chk
    import trap_entry_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              CODE_W     = 3,
    parameter int              IDIS_BIT   = 7,
    parameter logic [XLEN-1:0] HIVEC_BASE = 32'hFFFF_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_valid,
    input logic [CODE_W-1:0] exc_code,
    input logic [XLEN-1:0]   cur_pc,
    input logic [XLEN-1:0]   cur_status,
    input logic              hivec_en,
    input logic              done,
    input logic              err,
    input logic [XLEN-1:0]   new_pc,
    input logic [XLEN-1:0]   new_status,
    input logic [XLEN-1:0]   saved_status,
    input logic [XLEN-1:0]   link_val,
    input logic              bank_req,
    input logic [MODE_W-1:0] bank_old_mode,
    input logic [MODE_W-1:0] bank_new_mode
);

    p_done_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(exc_valid));

    p_err_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!done && !bank_req));

    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(new_pc) && $stable(new_status) && $stable(link_val)));

    p_idis_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> new_status[IDIS_BIT]);

    p_mode_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_status[MODE_W-1:0] == bank_new_mode));

    p_saved_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (saved_status == $past(cur_status)));

    p_link_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (link_val == $past(cur_pc)));

    p_bank_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bank_req |-> (done && (bank_old_mode != bank_new_mode)));

    p_low_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(hivec_en)) |-> (new_pc[XLEN-1:OFFS_W] == '0));

    p_high_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(hivec_en)) |-> (new_pc[XLEN-1:OFFS_W] == HIVEC_BASE[XLEN-1:OFFS_W]));

endmodule

bind trap_entry_seq trap_entry_seq_chk #(
    .XLEN(XLEN), .CODE_W(CODE_W), .IDIS_BIT(IDIS_BIT), .HIVEC_BASE(HIVEC_BASE)
) u_trap_entry_seq_chk (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .cur_pc(cur_pc), .cur_status(cur_status), .hivec_en(hivec_en),
    .done(done), .err(err), .new_pc(new_pc), .new_status(new_status),
    .saved_status(saved_status), .link_val(link_val), .bank_req(bank_req),
    .bank_old_mode(bank_old_mode), .bank_new_mode(bank_new_mode)
);

// File: tb/test_trap_entry_seq.sv
`timescale 1ns/1ps
module test_trap_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_valid;
    logic [2:0]  exc_code;
    logic [31:0] cur_pc;
    logic [31:0] cur_status;
    logic        hivec_en;
    logic        done, err, bank_req;
    logic [31:0] new_pc, new_status, saved_status, link_val;
    logic [4:0]  bank_old_mode, bank_new_mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // model of the result registers
    logic [31:0] m_pc = '0, m_status = '0, m_saved = '0, m_link = '0;

    always #5 clk = ~clk;

    trap_entry_seq i_trap_entry_seq (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
        .cur_pc(cur_pc), .cur_status(cur_status), .hivec_en(hivec_en),
        .done(done), .err(err), .new_pc(new_pc), .new_status(new_status),
        .saved_status(saved_status), .link_val(link_val), .bank_req(bank_req),
        .bank_old_mode(bank_old_mode), .bank_new_mode(bank_new_mode)
    );

    function automatic bit f_known(input logic [2:0] c);
        return (c >= 3'd1) && (c <= 3'd4);
    endfunction

    function automatic logic [4:0] f_mode(input logic [2:0] c);
        case (c)
            3'd1:    return 5'h13;
            3'd2:    return 5'h17;
            3'd3:    return 5'h17;
            3'd4:    return 5'h12;
            default: return 5'h00;
        endcase
    endfunction

    function automatic logic [31:0] f_vec(input logic [2:0] c, input logic hv);
        logic [31:0] off;
        case (c)
            3'd1:    off = 32'h08;
            3'd2:    off = 32'h0c;
            3'd3:    off = 32'h10;
            3'd4:    off = 32'h18;
            default: off = 32'h00;
        endcase
        return hv ? off + 32'hFFFF_0000 : off;
    endfunction

    function automatic logic [31:0] f_status(input logic [2:0] c, input logic [31:0] s);
        logic [31:0] r;
        r = s;
        r[4:0] = f_mode(c);
        r[7] = 1'b1;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd1:    return "R1";
            3'd2:    return "R2";
            3'd3:    return "R2";
            3'd4:    return "R3";
            default: return "R9";
        endcase
    endfunction

    // one strobe, check the next cycle, then one idle cycle
    task automatic apply(input logic [2:0] c, input logic [31:0] pc,
                         input logic [31:0] st, input logic hv, input bit keep_valid);
        logic [4:0] em;
        @(negedge clk);
        exc_valid  = 1'b1;
        exc_code   = c;
        cur_pc     = pc;
        cur_status = st;
        hivec_en   = hv;
        @(posedge clk);
        #2;
        if (f_known(c)) begin
            em = f_mode(c);
            m_pc = f_vec(c, hv);
            m_status = f_status(c, st);
            m_saved = st;
            m_link = pc;
            chk(done === 1'b1, "R10", "done after strobe", 32'(done), 32'd1);
            chk(err === 1'b0, "R10", "err on known code", 32'(err), 32'd0);
            chk(new_status[4:0] === em, req_of(c), "handler mode", 32'(new_status[4:0]), 32'(em));
            chk(new_pc === m_pc, hv ? "R4" : "R7", "vector", new_pc, m_pc);
            chk(new_status === m_status, "R5", "new status", new_status, m_status);
            chk(saved_status === m_saved, "R6", "saved status", saved_status, m_saved);
            chk(link_val === m_link, "R7", "link", link_val, m_link);
            chk(bank_req === (st[4:0] != em), "R8", "bank request", 32'(bank_req), 32'(st[4:0] != em));
            chk(bank_old_mode === st[4:0] && bank_new_mode === em, "R8", "bank modes",
                {bank_old_mode, bank_new_mode}, {st[4:0], em});
        end else begin
            chk(err === 1'b1, "R9", "err on unknown code", 32'(err), 32'd1);
            chk(done === 1'b0 && bank_req === 1'b0, "R9", "done/bank on unknown",
                {done, bank_req}, 32'd0);
            chk(new_pc === m_pc && new_status === m_status, "R9", "pc/status held",
                new_pc ^ new_status, m_pc ^ m_status);
            chk(saved_status === m_saved && link_val === m_link, "R9", "saved/link held",
                saved_status ^ link_val, m_saved ^ m_link);
        end
        if (!keep_valid) begin
            @(negedge clk);
            exc_valid = 1'b0;
            @(posedge clk);
            #2;
            chk(done === 1'b0 && err === 1'b0, "R10", "pulse ends", {done, err}, 32'd0);
            chk(new_pc === m_pc, "R10", "result holds when idle", new_pc, m_pc);
        end
    endtask

    initial begin
        rst_n = 1'b0; exc_valid = 1'b0; exc_code = '0;
        cur_pc = '0; cur_status = '0; hivec_en = 1'b0;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #2;
        chk(done === 1'b0 && err === 1'b0 && bank_req === 1'b0, "R11", "reset flags",
            {done, err, bank_req}, 32'd0);
        chk(new_pc === '0 && new_status === '0 && saved_status === '0 && link_val === '0,
            "R11", "reset data", new_pc | new_status | saved_status | link_val, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        apply(3'd5, 32'h1234_5678, 32'h0000_0010, 1'b0, 0);   // R9 before any entry
        apply(3'd1, 32'h0000_1000, 32'h0000_0010, 1'b0, 0);   // R1
        apply(3'd2, 32'h0000_2004, 32'hA5A5_A500, 1'b1, 0);   // R2, R4
        apply(3'd3, 32'h8000_0000, 32'hFFFF_FF7F, 1'b0, 0);   // R2, R5
        apply(3'd4, 32'hDEAD_BEEC, 32'h0000_0012, 1'b1, 0);   // R3, R8 same mode
        apply(3'd0, 32'h0BAD_0BAD, 32'h1111_1111, 1'b1, 0);   // R9 holds
        apply(3'd7, 32'h0, 32'h0, 1'b0, 0);                   // R9
        apply(3'd1, 32'h0000_0040, 32'h0000_0013, 1'b1, 1);   // back to back, R10
        apply(3'd4, 32'h0000_0044, 32'h0000_0017, 1'b0, 1);
        apply(3'd6, 32'h0000_0048, 32'h0000_0017, 1'b0, 0);

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [2:0]  c;
            logic [31:0] st;
            c  = 3'($urandom % 8);
            st = $urandom;
            if (($urandom % 4) == 0) st[4:0] = f_mode(c);
            apply(c, $urandom, st, 1'($urandom % 2), (($urandom % 3) == 0));
        end

        @(negedge clk);
        exc_valid = 1'b0;
        repeat (2) @(posedge clk);
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule